// File: doc/BRIEF.md
# Counter access and read-index decoder

This block is the register-access front end of a bank of performance counters. Software reaches each general-purpose counter through two write aliases. The legacy alias takes a 32-bit value and sign-extends it. The full-width alias takes the value as it is, but only when the value fits the counter. A third write region loads the fixed-function counters. On the read side, a 32-bit read index chooses the counter group and the counter number. The index also chooses a normal read or a fast read, which returns only the low 32 bits.

The block holds one register per counter. Both general-purpose aliases write that same register. The block drives a storage write port (`st_we`, `st_fix`, `st_num`, `st_data`) to the register bank, returns read data, and raises a fault flag on any access it refuses.

There is no back-pressure. A strobe is accepted in every cycle it is high. The fault flag and the read data are combinational, in the cycle of the strobe. A write lands in storage at the next rising clock edge. A read in the same cycle as a write sees the value from before the edge.

Top module: `pmc_access`

## Requirements
- R1: A write in region 0 (`wr_addr[SEL_W+1:SEL_W]` = 0, legacy alias) stores the low 32 data bits sign-extended from bit 31 and masked to `GP_W` bits. Data bits 63:32 are ignored and never cause a fault.
- R2: A write in region 1 (full-width alias) whose data has no bit set at or above `GP_W` stores the data unchanged.
- R3: A region 1 write with any bit set at or above `GP_W` raises the fault and leaves every counter unchanged.
- R4: Regions 0 and 1 write the same register for a given counter number `wr_addr[SEL_W-1:0]`, so a write through either alias replaces the value written through the other.
- R5: A region 2 write loads the fixed counter, masked to `FIX_W`, without a fault. A write in region 3, or to a counter number not implemented in its group, faults and changes nothing.
- R6: Read index bit 30 set selects the fixed group and clear selects the general group. Bits `SEL_W-1:0` give the counter number.
- R7: Read index bit 31 set requests a fast read, returning counter bits 31:0 zero-extended to 64 bits.
- R8: A read faults when the counter number is not implemented in its group, or when any index bit from 29 down to `SEL_W` is set (index 64, for example).
- R9: A normal read returns the counter value masked to its group width (`GP_W` or `FIX_W`).
- R10: The fault flag is high only in a cycle with an active strobe that is refused. The read data is zero on a faulting read and when no read is strobed.
- R11: Reset clears every counter to zero.
- R12: A write takes effect at the next rising edge. A read in the same cycle returns the previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_stb | input | 1 | Write strobe |
| wr_addr | input | SEL_W+2 | Region (top two bits) and counter number |
| wr_data | input | 64 | Write data |
| rd_stb | input | 1 | Read strobe |
| rd_idx | input | 32 | Read index: bit 31 fast, bit 30 fixed group, low bits counter number |
| st_we | output | 1 | Storage write enable |
| st_fix | output | 1 | Storage write targets the fixed group |
| st_num | output | SEL_W | Storage write counter number |
| st_data | output | 64 | Value written into storage |
| rd_data | output | 64 | Read result |
| fault | output | 1 | Access refused |

## Verification
Legacy writes are driven with bit 31 clear and then set, with junk in the upper 32 bits. This separates proper sign extension from zero extension and from passing the upper half through. Full-width writes are driven with bit 47 set, which must be accepted, and with bit 48 set, which must fault and leave the stored value in place on the next read. Fast and normal reads of the same counter, one of them holding a sign-extended value, show that the upper bits are zeroed. Reads with bit 6, bit 29 or a low reserved bit set, and a read of a missing fixed counter, each exercise a separate fault cause. A same-cycle write and read of one counter confirms that the read returns the old value.

// File: rtl/pmc_acc_pkg.sv
package pmc_acc_pkg;

  typedef enum logic [1:0] {
    REG_LEGACY = 2'd0,
    REG_FULL   = 2'd1,
    REG_FIXED  = 2'd2,
    REG_RSVD   = 2'd3
  } wr_region_e;

  localparam int DATA_W = 64;
  localparam int IDX_W  = 32;
  localparam int FAST_BIT  = 31;
  localparam int GROUP_BIT = 30;

  // Low-order ones mask of the given width (width 1..64).
  function automatic logic [DATA_W-1:0] width_mask(input int w);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < DATA_W; i++) m[i] = (i < w);
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] sext32(input logic [31:0] v);
    return {{32{v[31]}}, v};
  endfunction

endpackage

// File: rtl/pmc_wr_decode.sv
module pmc_wr_decode
  import pmc_acc_pkg::*;
#(
  parameter int NUM_GP  = 4,
  parameter int NUM_FIX = 3,
  parameter int GP_W    = 48,
  parameter int FIX_W   = 40,
  parameter int SEL_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [SEL_W+1:0]  wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              st_we,
  output logic              st_fix,
  output logic [SEL_W-1:0]  st_num,
  output logic [DATA_W-1:0] st_data,
  output logic              wr_fault
);

  localparam logic [DATA_W-1:0] GP_MASK  = width_mask(GP_W);
  localparam logic [DATA_W-1:0] FIX_MASK = width_mask(FIX_W);

  wr_region_e        region;
  logic [SEL_W-1:0]  num;
  logic              num_ok_gp, num_ok_fix;
  logic              over_width;
  logic              accept;
  logic [DATA_W-1:0] value;

  assign region = wr_region_e'(wr_addr[SEL_W+1:SEL_W]);
  assign num    = wr_addr[SEL_W-1:0];

  assign num_ok_gp  = (int'(num) < NUM_GP);
  assign num_ok_fix = (int'(num) < NUM_FIX);
  assign over_width = |(wr_data & ~GP_MASK);

  always_comb begin
    accept = 1'b0;
    value  = '0;
    unique case (region)
      REG_LEGACY: begin
        accept = num_ok_gp;
        value  = sext32(wr_data[31:0]) & GP_MASK;
      end
      REG_FULL: begin
        accept = num_ok_gp && !over_width;
        value  = wr_data;
      end
      REG_FIXED: begin
        accept = num_ok_fix;
        value  = wr_data & FIX_MASK;
      end
      default: begin
        accept = 1'b0;
        value  = '0;
      end
    endcase
  end

  assign st_we    = wr_stb && accept;
  assign st_fix   = (region == REG_FIXED);
  assign st_num   = num;
  assign st_data  = st_we ? value : '0;
  assign wr_fault = wr_stb && !accept;

  AST_LEGACY_NEVER_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && region == REG_LEGACY && num_ok_gp) |-> (st_we && !wr_fault)); // R1
  AST_WRITE_XOR_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    st_we |-> !wr_fault); // R3
  AST_STORED_FITS_GP: assert property (@(posedge clk) disable iff (!rst_n)
    (st_we && !st_fix) |-> ((st_data & ~GP_MASK) == '0)); // R2
  AST_RSVD_REGION_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && region == REG_RSVD) |-> (wr_fault && !st_we)); // R5

endmodule

// File: rtl/pmc_bank.sv
module pmc_bank
  import pmc_acc_pkg::*;
#(
  parameter int NUM_GP  = 4,
  parameter int NUM_FIX = 3,
  parameter int GP_W    = 48,
  parameter int FIX_W   = 40,
  parameter int SEL_W   = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          st_we,
  input  logic                          st_fix,
  input  logic [SEL_W-1:0]              st_num,
  input  logic [DATA_W-1:0]             st_data,
  output logic [NUM_GP-1:0][DATA_W-1:0] gp_q,
  output logic [NUM_FIX-1:0][DATA_W-1:0] fix_q
);

  localparam logic [DATA_W-1:0] GP_MASK  = width_mask(GP_W);
  localparam logic [DATA_W-1:0] FIX_MASK = width_mask(FIX_W);

  for (genvar g = 0; g < NUM_GP; g++) begin : g_gp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   gp_q[g] <= '0;
      else if (st_we && !st_fix && int'(st_num) == g) gp_q[g] <= st_data & GP_MASK;
    end
  end

  for (genvar f = 0; f < NUM_FIX; f++) begin : g_fix
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    fix_q[f] <= '0;
      else if (st_we && st_fix && int'(st_num) == f) fix_q[f] <= st_data & FIX_MASK;
    end
  end

  AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !st_we |=> ($stable(gp_q) && $stable(fix_q))); // R3
  AST_WRITE_LANDS_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_we && !st_fix && st_num == '0) |=> (gp_q[0] == $past(st_data & GP_MASK))); // R12

endmodule

// File: rtl/pmc_rd_decode.sv
module pmc_rd_decode
  import pmc_acc_pkg::*;
#(
  parameter int NUM_GP  = 4,
  parameter int NUM_FIX = 3,
  parameter int GP_W    = 48,
  parameter int FIX_W   = 40,
  parameter int SEL_W   = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           rd_stb,
  input  logic [IDX_W-1:0]               rd_idx,
  input  logic [NUM_GP-1:0][DATA_W-1:0]  gp_q,
  input  logic [NUM_FIX-1:0][DATA_W-1:0] fix_q,
  output logic [DATA_W-1:0]              rd_data,
  output logic                           rd_fault
);

  localparam logic [DATA_W-1:0] GP_MASK  = width_mask(GP_W);
  localparam logic [DATA_W-1:0] FIX_MASK = width_mask(FIX_W);

  logic              fast, fixed_grp;
  logic [SEL_W-1:0]  num;
  logic [29:0]       low_field;
  logic              rsvd_set;
  logic              num_ok;
  logic [DATA_W-1:0] gp_val, fix_val, sel_val;

  assign fast      = rd_idx[FAST_BIT];
  assign fixed_grp = rd_idx[GROUP_BIT];
  assign num       = rd_idx[SEL_W-1:0];
  assign low_field = rd_idx[29:0];
  assign rsvd_set  = |(low_field >> SEL_W);
  assign num_ok    = fixed_grp ? (int'(num) < NUM_FIX) : (int'(num) < NUM_GP);

  always_comb begin
    gp_val = '0;
    for (int i = 0; i < NUM_GP; i++)
      if (int'(num) == i) gp_val = gp_q[i];
  end

  always_comb begin
    fix_val = '0;
    for (int i = 0; i < NUM_FIX; i++)
      if (int'(num) == i) fix_val = fix_q[i];
  end

  assign sel_val  = fixed_grp ? (fix_val & FIX_MASK) : (gp_val & GP_MASK);
  assign rd_fault = rd_stb && (rsvd_set || !num_ok);

  always_comb begin
    if (!rd_stb || rd_fault) rd_data = '0;
    else if (fast)           rd_data = {32'd0, sel_val[31:0]};
    else                     rd_data = sel_val;
  end

  AST_FAST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && fast) |-> (rd_data[63:32] == '0)); // R7
  AST_FAULT_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fault |-> (rd_data == '0)); // R10
  AST_GP_READ_IN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !fixed_grp) |-> ((rd_data & ~GP_MASK) == '0)); // R9
  AST_RSVD_BITS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && rsvd_set) |-> rd_fault); // R8

endmodule

// File: rtl/pmc_access.sv
module pmc_access
  import pmc_acc_pkg::*;
#(
  parameter int NUM_GP  = 4,
  parameter int NUM_FIX = 3,
  parameter int GP_W    = 48,
  parameter int FIX_W   = 40,
  localparam int MAX_N  = (NUM_GP > NUM_FIX) ? NUM_GP : NUM_FIX,
  localparam int SEL_W  = (MAX_N > 1) ? $clog2(MAX_N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [SEL_W+1:0]  wr_addr,
  input  logic [63:0]       wr_data,
  input  logic              rd_stb,
  input  logic [31:0]       rd_idx,
  output logic              st_we,
  output logic              st_fix,
  output logic [SEL_W-1:0]  st_num,
  output logic [63:0]       st_data,
  output logic [63:0]       rd_data,
  output logic              fault
);

  logic                           wr_fault, rd_fault;
  logic [NUM_GP-1:0][DATA_W-1:0]  gp_q;
  logic [NUM_FIX-1:0][DATA_W-1:0] fix_q;

  pmc_wr_decode #(
    .NUM_GP(NUM_GP), .NUM_FIX(NUM_FIX), .GP_W(GP_W), .FIX_W(FIX_W), .SEL_W(SEL_W)
  ) u_wr (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .st_we(st_we), .st_fix(st_fix), .st_num(st_num), .st_data(st_data),
    .wr_fault(wr_fault)
  );

  pmc_bank #(
    .NUM_GP(NUM_GP), .NUM_FIX(NUM_FIX), .GP_W(GP_W), .FIX_W(FIX_W), .SEL_W(SEL_W)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .st_we(st_we), .st_fix(st_fix), .st_num(st_num),
    .st_data(st_data), .gp_q(gp_q), .fix_q(fix_q)
  );

  pmc_rd_decode #(
    .NUM_GP(NUM_GP), .NUM_FIX(NUM_FIX), .GP_W(GP_W), .FIX_W(FIX_W), .SEL_W(SEL_W)
  ) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .rd_idx(rd_idx),
    .gp_q(gp_q), .fix_q(fix_q), .rd_data(rd_data), .rd_fault(rd_fault)
  );

  assign fault = wr_fault || rd_fault;

  AST_FAULT_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (wr_stb || rd_stb)); // R10
  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |-> !st_we); // R10

endmodule

// File: tb/pmc_access_tb_top.sv
module pmc_access_tb_top;

  typedef struct packed {
    logic        ws;
    logic [3:0]  wa;
    logic [63:0] wd;
    logic        rs;
    logic [31:0] ri;
    logic        ef;
    logic [63:0] er;
    logic [63:0] ew;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 4'h0, 64'h0, 1'b1, 32'h0, 1'b0, 64'h0, 64'h0, 8'd11},                                   // R11 reset value
    '{1'b1, 4'h0, 64'h0000_ff01_2345_6789, 1'b0, 32'h0, 1'b0, 64'h0, 64'h0000_0000_2345_6789, 8'd1},  // R1
    '{1'b0, 4'h0, 64'h0, 1'b1, 32'h0, 1'b0, 64'h0000_0000_2345_6789, 64'h0, 8'd1},                   // R1
    '{1'b1, 4'h1, 64'hffff_ff01_89ab_cdef, 1'b0, 32'h0, 1'b0, 64'h0, 64'h0000_ffff_89ab_cdef, 8'd1},  // R1 sign
    '{1'b0, 4'h0, 64'h0, 1'b1, 32'h1, 1'b0, 64'h0000_ffff_89ab_cdef, 64'h0, 8'd9},                   // R9
    '{1'b1, 4'h6, 64'h0000_8123_4567_89ab, 1'b0, 32'h0, 1'b0, 64'h0, 64'h0000_8123_4567_89ab, 8'd2},  // R2
    '{1'b0, 4'h0, 64'h0, 1'b1, 32'h2, 1'b0, 64'h0000_8123_4567_89ab, 64'h0, 8'd2},                   // R2
    '{1'b1, 4'h6, 64'h0001_0000_0000_0000, 1'b0, 32'h0, 1'b1, 64'h0, 64'h0, 8'd3},                   // R3
    '{1'b0, 4'h0, 64'h0, 1'b1, 32'h2, 1'b0, 64'h0000_8123_4567_89ab, 64'h0, 8'd3},                   // R3 unchanged
    '{1'b0, 4'h0, 64'h0, 1'b1, 32'h8000_0002, 1'b0, 64'h0000_0000_4567_89ab, 64'h0, 8'd7},           // R7
    '{1'b1, 4'h9, 64'hffff_ff12_3456_789a, 1'b0, 32'h0, 1'b0, 64'h0, 64'h0000_0012_3456_789a, 8'd5},  // R5 fixed
    '{1'b0, 4'h0, 64'h0, 1'b1, 32'h4000_0001, 1'b0, 64'h0000_0012_3456_789a, 64'h0, 8'd6},           // R6
    '{1'b0, 4'h0, 64'h0, 1'b1, 32'hc000_0001, 1'b0, 64'h0000_0000_3456_789a, 64'h0, 8'd7},           // R7 fixed
    '{1'b0, 4'h0, 64'h0, 1'b1, 32'd64, 1'b1, 64'h0, 64'h0, 8'd8},                                    // R8
    '{1'b0, 4'h0, 64'h0, 1'b1, 32'h4000_0003, 1'b1, 64'h0, 64'h0, 8'd8},                             // R8 missing fixed
    '{1'b0, 4'h0, 64'h0, 1'b1, 32'h2000_0000, 1'b1, 64'h0, 64'h0, 8'd8},                             // R8 bit 29
    '{1'b1, 4'hc, 64'h5, 1'b0, 32'h0, 1'b1, 64'h0, 64'h0, 8'd5},                                     // R5 region 3
    '{1'b0, 4'h0, 64'h0, 1'b1, 32'h0, 1'b0, 64'h0000_0000_2345_6789, 64'h0, 8'd5},                   // R5 no change
    '{1'b1, 4'hb, 64'h5, 1'b0, 32'h0, 1'b1, 64'h0, 64'h0, 8'd5},                                     // R5 missing fixed
    '{1'b1, 4'h2, 64'h7, 1'b0, 32'h0, 1'b0, 64'h0, 64'h7, 8'd4},                                     // R4
    '{1'b0, 4'h0, 64'h0, 1'b1, 32'h2, 1'b0, 64'h7, 64'h0, 8'd4},                                     // R4 shared
    '{1'b1, 4'h7, 64'h1234, 1'b1, 32'h3, 1'b0, 64'h0, 64'h1234, 8'd12},                              // R12 same cycle
    '{1'b0, 4'h0, 64'h0, 1'b1, 32'h3, 1'b0, 64'h1234, 64'h0, 8'd12},                                 // R12
    '{1'b0, 4'h0, 64'h0, 1'b0, 32'h0, 1'b0, 64'h0, 64'h0, 8'd10},                                    // R10 idle
    '{1'b0, 4'h0, 64'h0, 1'b1, 32'h8000_0001, 1'b0, 64'h0000_0000_89ab_cdef, 64'h0, 8'd7},           // R7 no sign
    '{1'b0, 4'h0, 64'h0, 1'b1, 32'h4, 1'b1, 64'h0, 64'h0, 8'd8}                                      // R8 low reserved
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_stb = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [63:0] wr_data = '0;
  logic        rd_stb = 1'b0;
  logic [31:0] rd_idx = '0;
  logic        st_we, st_fix;
  logic [1:0]  st_num;
  logic [63:0] st_data, rd_data;
  logic        fault;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  pmc_access dut_i (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_stb(rd_stb), .rd_idx(rd_idx), .st_we(st_we), .st_fix(st_fix), .st_num(st_num),
    .st_data(st_data), .rd_data(rd_data), .fault(fault)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic ws, input logic [3:0] wa, input logic [63:0] wd,
                       input logic rs, input logic [31:0] ri);
    @(negedge clk);
    wr_stb = ws; wr_addr = wa; wr_data = wd; rd_stb = rs; rd_idx = ri;
    #1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(4 * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      string tag;
      tag = $sformatf("R%0d row %0d", VEC[k].req, k);
      drive(VEC[k].ws, VEC[k].wa, VEC[k].wd, VEC[k].rs, VEC[k].ri);
      check({tag, " fault"}, {63'd0, fault}, {63'd0, VEC[k].ef});
      check({tag, " rd_data"}, rd_data, VEC[k].er);
      if (VEC[k].ws) begin
        check({tag, " st_we"}, {63'd0, st_we}, {63'd0, !VEC[k].ef});
        if (!VEC[k].ef) check({tag, " st_data"}, st_data, VEC[k].ew);
      end
    end

    // R10: fault lasts only while the refused strobe is high
    drive(1'b0, 4'h0, 64'h0, 1'b1, 32'd64);
    check("R10 fault with strobe", {63'd0, fault}, 64'd1);
    drive(1'b0, 4'h0, 64'h0, 1'b0, 32'd64);
    check("R10 fault drops", {63'd0, fault}, 64'd0);
    check("R10 idle data", rd_data, 64'd0);

    // R11: reset clears both groups
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    drive(1'b0, 4'h0, 64'h0, 1'b1, 32'h2);
    check("R11 gp2 after reset", rd_data, 64'd0);
    drive(1'b0, 4'h0, 64'h0, 1'b1, 32'h4000_0001);
    check("R11 fixed1 after reset", rd_data, 64'd0);

    drive(1'b0, 4'h0, 64'h0, 1'b0, 32'h0);
    finish_run();
  end

endmodule